// File: doc/BRIEF.md
# Eight-Digit Fixed-Point Display Decoder with Zero Suppression

The block holds a fixed-point decimal number of four integer digits and four fraction digits and turns it into segment patterns for eight seven-segment digits plus a marker for the decimal point. It suppresses zeros that carry no information. Zeros ahead of the first significant integer digit go dark, and so do zeros after the last significant fraction digit. The two digits on either side of the point always stay lit. As a result, 0060.0300 reads as 60.03 and a zero value reads as 0.0.

A new value is captured on a rising clock edge while the active-low load strobe is low, and it is held while the strobe is high. The segment outputs are decoded combinationally from the held value. An active-low dim strobe switches every segment and the point marker off while it is low. Driving that strobe with a pulse train sets the apparent brightness through the duty cycle.

Each digit is decoded by its own cell. The cells pass a blanking signal from one to the next. In the integer part it starts at the most significant digit and moves toward the point. In the fraction part it starts at the least significant digit and moves toward the point.

Top module: `zsup_display`

## Requirements
- R1: With `load_n` low at a rising `clk` edge, all eight digit codes on `digits_in` are captured. With `load_n` high, the held value does not change, whatever `digits_in` does.
- R2: A lit digit shows its held code in hexadecimal font. The segment vector bit order is {g,f,e,d,c,b,a}, and a lit segment is 1. Codes 0..F map to 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R3: An integer digit (slots 4..7, slot 7 most significant) other than slot 4 is dark when it and every more significant integer digit hold 0.
- R4: The integer digit at slot 4, next to the point, is never blanked for zero.
- R5: A fraction digit (slots 0..3, slot 0 least significant) other than slot 3 is dark when it and every less significant fraction digit hold 0.
- R6: The fraction digit at slot 3, just after the point, is never blanked for zero.
- R7: While `dim_n` is low, every segment output and the point marker are 0. The held value is unaffected and shows again once `dim_n` returns high.
- R8: While `dim_n` is high, `dp_mark` has exactly bit 4 set, which marks the point after the slot 4 digit.
- R9: After reset the held value is all zero, so the display shows 0.0.
- R10: Codes 10..15 count as nonzero. They stop suppression like any other nonzero digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low capture strobe for the digit codes |
| digits_in | input | 32 | Eight 4-bit codes; slot k sits at bits [4k+3:4k], slot 0 is the last fraction digit |
| dim_n | input | 1 | Active-low blank strobe for intensity modulation |
| segs_out | output | 56 | Eight segment vectors; slot k sits at bits [7k+6:7k] |
| dp_mark | output | 8 | Decimal-point marker, one bit per slot |

## Verification
The value 0060.0300 checks that both chains run at the same time, each in its own direction. All-zero, integer-only and fraction-only values check that the digits next to the point stay lit when one side or both sides are empty. A single nonzero digit walked through all eight slots shows which neighbours go dark in each position. Values with inner zeros and hexadecimal letters confirm that suppression stops at the first significant code. Hold and dim sequences confirm that neither the ignored inputs nor blanking disturb the held value.

// File: rtl/zsup_pkg.sv
package zsup_pkg;

   localparam int CODE_W = 4;
   localparam int SEG_W  = 7;

   typedef logic [CODE_W-1:0] code_t;
   typedef logic [SEG_W-1:0]  seg_t;

   // Segment order {g,f,e,d,c,b,a}, lit = 1
   function automatic seg_t hex_glyph(input code_t c);
      seg_t s;
      case (c)
         4'h0: s = 7'h3F;
         4'h1: s = 7'h06;
         4'h2: s = 7'h5B;
         4'h3: s = 7'h4F;
         4'h4: s = 7'h66;
         4'h5: s = 7'h6D;
         4'h6: s = 7'h7D;
         4'h7: s = 7'h07;
         4'h8: s = 7'h7F;
         4'h9: s = 7'h6F;
         4'hA: s = 7'h77;
         4'hB: s = 7'h7C;
         4'hC: s = 7'h39;
         4'hD: s = 7'h5E;
         4'hE: s = 7'h79;
         default: s = 7'h71;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/zsup_digit_reg.sv
module zsup_digit_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (!load_n)
         q <= d;
   end

endmodule

// File: rtl/zsup_digit_cell.sv
module zsup_digit_cell
   import zsup_pkg::*;
(
   input  code_t code,
   input  logic  rbi_n,
   input  logic  dim_n,
   output seg_t  seg,
   output logic  rbo_n
);

   logic is_zero;
   logic ripple_dark;

   assign is_zero     = (code == '0);
   assign ripple_dark = !rbi_n && is_zero;
   assign rbo_n       = !ripple_dark;
   assign seg         = (ripple_dark || !dim_n) ? '0 : hex_glyph(code);

endmodule

// File: rtl/zsup_display.sv
module zsup_display
   import zsup_pkg::*;
#(
   parameter  int INT_DIGITS     = 4,
   parameter  int FRAC_DIGITS    = 4,
   parameter  bit ACTIVE_LOW_OUT = 1'b0,
   localparam int NUM            = INT_DIGITS + FRAC_DIGITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_n,
   input  logic [NUM*CODE_W-1:0] digits_in,
   input  logic                 dim_n,
   output logic [NUM*SEG_W-1:0]  segs_out,
   output logic [NUM-1:0]        dp_mark
);

   localparam int PT_SLOT = FRAC_DIGITS;   // integer digit carrying the point
   localparam int MSD     = NUM - 1;

   if (INT_DIGITS < 1) begin : g_bad_int
      $error("zsup_display: INT_DIGITS must be at least 1");
   end
   if (FRAC_DIGITS < 1) begin : g_bad_frac
      $error("zsup_display: FRAC_DIGITS must be at least 1");
   end

   logic [NUM*CODE_W-1:0] digit_q;
   logic [NUM*SEG_W-1:0]  seg_raw;
   logic [NUM-1:0]        rbi_n;
   logic [NUM-1:0]        rbo_n;
   logic [NUM-1:0]        dp_raw;
   logic                  unused_rbo;

   for (genvar k = 0; k < NUM; k++) begin : g_slot
      zsup_digit_reg #(.W(CODE_W)) u_reg (
         .clk    (clk),
         .rst_n  (rst_n),
         .load_n (load_n),
         .d      (digits_in[k*CODE_W +: CODE_W]),
         .q      (digit_q[k*CODE_W +: CODE_W])
      );

      // Blanking chain: integer part ripples downward from the MSD,
      // fraction part ripples upward from slot 0; point neighbours fixed lit.
      if (k == PT_SLOT || k == PT_SLOT - 1) begin : g_keep
         assign rbi_n[k] = 1'b1;
      end else if (k == MSD || k == 0) begin : g_head
         assign rbi_n[k] = 1'b0;
      end else if (k > PT_SLOT) begin : g_int
         assign rbi_n[k] = rbo_n[k+1];
      end else begin : g_frac
         assign rbi_n[k] = rbo_n[k-1];
      end

      zsup_digit_cell u_cell (
         .code  (digit_q[k*CODE_W +: CODE_W]),
         .rbi_n (rbi_n[k]),
         .dim_n (dim_n),
         .seg   (seg_raw[k*SEG_W +: SEG_W]),
         .rbo_n (rbo_n[k])
      );

      assign dp_raw[k] = (k == PT_SLOT) ? dim_n : 1'b0;
   end

   assign unused_rbo = &{1'b0, rbo_n};

   if (ACTIVE_LOW_OUT) begin : g_out_low
      assign segs_out = ~seg_raw;
      assign dp_mark  = ~dp_raw;
   end else begin : g_out_high
      assign segs_out = seg_raw;
      assign dp_mark  = dp_raw;
   end

endmodule

// File: rtl/zsup_display_chk.sv
module zsup_display_chk
   import zsup_pkg::*;
#(
   parameter  int INT_DIGITS     = 4,
   parameter  int FRAC_DIGITS    = 4,
   parameter  bit ACTIVE_LOW_OUT = 1'b0,
   localparam int NUM            = INT_DIGITS + FRAC_DIGITS
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  load_n,
   input logic                  dim_n,
   input logic [NUM*CODE_W-1:0] digits_in,
   input logic [NUM*CODE_W-1:0] digit_q,
   input logic [NUM*SEG_W-1:0]  segs_out,
   input logic [NUM-1:0]        dp_mark
);

   localparam int PT = FRAC_DIGITS;

   logic [NUM*SEG_W-1:0] lit;
   logic [NUM-1:0]       dp_lit;
   logic [NUM-1:0]       pt_onehot;
   assign lit       = ACTIVE_LOW_OUT ? ~segs_out : segs_out;
   assign dp_lit    = ACTIVE_LOW_OUT ? ~dp_mark  : dp_mark;
   assign pt_onehot = NUM'(1) << PT;

   AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |=> digit_q == $past(digits_in)); // R1
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      load_n |=> $stable(digit_q)); // R1
   AST_DIM_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      !dim_n |-> (lit == '0 && dp_lit == '0)); // R7
   AST_INT_POINT_LIT: assert property (@(posedge clk) disable iff (!rst_n)
      dim_n |-> lit[PT*SEG_W +: SEG_W] != '0); // R4
   AST_FRAC_POINT_LIT: assert property (@(posedge clk) disable iff (!rst_n)
      dim_n |-> lit[(PT-1)*SEG_W +: SEG_W] != '0); // R6
   AST_POINT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      dim_n |-> dp_lit == pt_onehot); // R8

   for (genvar k = PT + 1; k < NUM - 1; k++) begin : g_int_chain
      AST_INT_RIPPLE: assert property (@(posedge clk) disable iff (!rst_n)
         (dim_n && lit[k*SEG_W +: SEG_W] == '0) |-> lit[(k+1)*SEG_W +: SEG_W] == '0); // R3
   end

   for (genvar k = 1; k < PT - 1; k++) begin : g_frac_chain
      AST_FRAC_RIPPLE: assert property (@(posedge clk) disable iff (!rst_n)
         (dim_n && lit[k*SEG_W +: SEG_W] == '0) |-> lit[(k-1)*SEG_W +: SEG_W] == '0); // R5
   end

endmodule

bind zsup_display zsup_display_chk #(
   .INT_DIGITS     (INT_DIGITS),
   .FRAC_DIGITS    (FRAC_DIGITS),
   .ACTIVE_LOW_OUT (ACTIVE_LOW_OUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load_n    (load_n),
   .dim_n     (dim_n),
   .digits_in (digits_in),
   .digit_q   (digit_q),
   .segs_out  (segs_out),
   .dp_mark   (dp_mark)
);

// File: tb/zsup_display_test.sv
module zsup_display_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_n = 1'b1;
   logic [31:0] digits_in = '0;
   logic        dim_n = 1'b1;
   logic [55:0] segs_out;
   logic [7:0]  dp_mark;

   int n_checks = 0;
   int n_fail   = 0;
   logic [31:0] shadow = '0;

   always #2 clk = ~clk;   // 250 MHz

   zsup_display uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_n    (load_n),
      .digits_in (digits_in),
      .dim_n     (dim_n),
      .segs_out  (segs_out),
      .dp_mark   (dp_mark)
   );

   function automatic logic [6:0] font(input logic [3:0] c);
      case (c)
         4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
         4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
         4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
         4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
      endcase
   endfunction

   // Expected picture from R2..R6 and R10
   function automatic logic [55:0] expect_segs(input logic [31:0] v, input logic dim);
      logic [55:0] e = '0;
      for (int k = 0; k < 8; k++) begin
         logic dark = 1'b0;
         if (k >= 5) begin
            dark = 1'b1;
            for (int j = k; j < 8; j++) if (v[j*4 +: 4] != 0) dark = 1'b0;
         end else if (k <= 2) begin
            dark = 1'b1;
            for (int j = 0; j <= k; j++) if (v[j*4 +: 4] != 0) dark = 1'b0;
         end
         if (dim && !dark) e[k*7 +: 7] = font(v[k*4 +: 4]);
      end
      return e;
   endfunction

   task automatic check(input string req, input logic [55:0] exp_s, input logic [7:0] exp_dp);
      n_checks++;
      if (segs_out !== exp_s || dp_mark !== exp_dp) begin
         n_fail++;
         $display("FAIL %s: segs=%h dp=%b expected segs=%h dp=%b", req, segs_out, dp_mark, exp_s, exp_dp);
      end
   endtask

   task automatic check_model(input string req);
      check(req, expect_segs(shadow, dim_n), dim_n ? 8'b0001_0000 : 8'h00);
   endtask

   task automatic load(input logic [31:0] v);
      @(negedge clk);
      digits_in = v;
      load_n = 1'b0;
      @(negedge clk);
      load_n = 1'b1;
      shadow = v;
   endtask

   task automatic t_reset;
      // R9: 0.0 after reset, R8 marker
      check("R9", {7'h00, 7'h00, 7'h00, 7'h3F, 7'h3F, 7'h00, 7'h00, 7'h00}, 8'b0001_0000);
   endtask

   task automatic t_example;
      load(32'h0060_0300);   // R3 R5: shows 60.03
      check("R3_R5", {7'h00, 7'h00, 7'h7D, 7'h3F, 7'h3F, 7'h4F, 7'h00, 7'h00}, 8'b0001_0000);
   endtask

   task automatic t_all_zero;
      load(32'h0000_0000);   // R4 R6
      check("R4_R6", {7'h00, 7'h00, 7'h00, 7'h3F, 7'h3F, 7'h00, 7'h00, 7'h00}, 8'b0001_0000);
   endtask

   task automatic t_int_only;
      load(32'h1234_0000);   // R6: 1234.0
      check("R6", {7'h06, 7'h5B, 7'h4F, 7'h66, 7'h3F, 7'h00, 7'h00, 7'h00}, 8'b0001_0000);
   endtask

   task automatic t_frac_only;
      load(32'h0000_5678);   // R4: 0.5678
      check("R4", {7'h00, 7'h00, 7'h00, 7'h3F, 7'h6D, 7'h7D, 7'h07, 7'h7F}, 8'b0001_0000);
   endtask

   task automatic t_inner_zeros;
      load(32'h1000_0001);   // R3 R5: inner zeros shown
      check_model("R3");
      load(32'h0007_7000);
      check_model("R5");
   endtask

   task automatic t_hex;
      load(32'hA0F0_0B00);   // R10 R2
      check("R10", {7'h77, 7'h3F, 7'h71, 7'h3F, 7'h3F, 7'h7C, 7'h00, 7'h00}, 8'b0001_0000);
      load(32'h0C00_00E0);
      check_model("R10");
   endtask

   task automatic t_walk;
      for (int k = 0; k < 8; k++) begin
         load(32'h9 << (4 * k));   // R3 R5 single digit in each slot
         check_model(k >= 4 ? "R3" : "R5");
      end
   endtask

   task automatic t_hold;
      load(32'h4321_8765);
      @(negedge clk);
      digits_in = 32'hFFFF_FFFF;   // R1: ignored while load_n high
      repeat (3) @(negedge clk);
      check_model("R1");
      load(32'h0005_5000);
      check_model("R1");
   endtask

   task automatic t_dim;
      load(32'h0123_4560);
      dim_n = 1'b0;
      #1;
      check("R7", 56'h0, 8'h00);
      @(negedge clk);
      check("R7", 56'h0, 8'h00);
      dim_n = 1'b1;
      #1;
      check_model("R7");   // value survives blanking, R8 marker back
   endtask

   initial begin
      #(200000 * 4);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_example();
      t_all_zero();
      t_int_only();
      t_frac_only();
      t_inner_zeros();
      t_hex();
      t_walk();
      t_hold();
      t_dim();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule